// File: doc/BRIEF.md
# Fault-Only-First Segment Load Sequencer

This block runs one unit-stride vector segment load in which only the first processed element may raise a trap. After a start pulse it captures the element width (SEW), the register grouping (LMUL), the field count minus one (NF), the memory item size, the signedness, the mask enable, the destination register, the current vector length and the start index. It then walks the element indices from zero up to VLMAX. For each active element it reads every field from memory, one request at a time. It sign- or zero-extends each item to SEW and merges the item into a small model of the vector register file.

A memory fault on the very first processed element ends the operation with a trap and the faulting address. A fault on any later element is not a trap. Instead the vector length is cut to the number of elements already processed and the instruction retires normally. Elements at or above the original vector length are written with zero. A register read port lets the surrounding logic, or a bench, observe the register file.

Top module: `fof_seg_loader`

## Requirements
- R1: The operation is rejected (ill=1 in the done cycle, vl_out=vl_in, vstart_out=vstart_in, no memory request and no register write) when vtype_bad=1, or when vm=0 and rd=0, or when (NF+1)·LMUL exceeds 32, or when msz is 0, 1 or 2 and msz is greater than sew_sel.
- R2: Within an element, fields are read in the order NF down to 0. Field k of element i is read at base + (i·(NF+1)+k)·B. B is the item size in bytes: 1<<msz, or SEW/8 when msz=3. req_size carries log2(B).
- R3: Field k of element i lands in register (rd + i/(VLEN/SEW) + k·LMUL) mod 32, at bit offset (i mod (VLEN/SEW))·SEW, with SEW bits wide. All other bits of that register are kept. Here SEW is 8<<sew_sel and LMUL is 1<<lmul_sel.
- R4: An item of 1, 2 or 4 bytes is sign-extended to SEW when sgn=1 and zero-extended when sgn=0. Only the low B bytes of rsp_data are used. With msz=3 the item is already SEW wide.
- R5: Elements with index below vstart_in cause no request and no write. A masked-off element (vm=0 and mask[i]=0) causes no request and no write, but it still adds one to the running count.
- R6: Every field of every element with index from max(vl_in, vstart_in) up to VLMAX-1 is written with zero, where VLMAX = VLEN·LMUL/SEW.
- R7: When no fault occurs, done reports vl_out=vl_in, vstart_out=0 and trap=0.
- R8: A fault while the running count is nonzero ends the operation at once. It gives trap=0, vl_out equal to the running count and vstart_out=0, and no further request or write follows.
- R9: A fault while the running count is zero gives trap=1, trap_addr equal to the faulting address, vl_out=vl_in and vstart_out equal to the index of the faulting element.
- R10: At most one memory request is outstanding. req is a one-cycle pulse, and exactly one request is made for each field read.
- R11: After reset, register r holds the byte 0x80|r repeated across its width, and done and req are low.
- R12: done is a one-cycle pulse for each accepted start. A start pulse that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| sew_sel | input | 2 | SEW = 8<<sew_sel |
| lmul_sel | input | 2 | LMUL = 1<<lmul_sel |
| nf | input | 3 | Fields per segment minus one |
| msz | input | 2 | Item size: 0 byte, 1 half, 2 word, 3 SEW |
| sgn | input | 1 | Sign-extend items narrower than SEW |
| vm | input | 1 | 1 = all elements active, 0 = use mask |
| vtype_bad | input | 1 | Vector type is invalid |
| rd | input | 5 | First destination register |
| vl_in | input | IW | Current vector length |
| vstart_in | input | IW | First element index to process |
| base | input | AW | Base byte address |
| mask | input | VLEN | Per-element mask bits |
| req | output | 1 | Memory read request pulse |
| req_addr | output | AW | Request byte address |
| req_size | output | 2 | log2 of request size in bytes |
| rsp_valid | input | 1 | Memory response strobe |
| rsp_data | input | 64 | Response data, little-endian |
| rsp_fault | input | 1 | Response is a fault |
| done | output | 1 | Completion pulse |
| ill | output | 1 | Operation was rejected |
| trap | output | 1 | Trap on the first element |
| trap_addr | output | AW | Faulting address |
| vl_out | output | IW | Resulting vector length |
| vstart_out | output | IW | Resulting start index |
| rf_raddr | input | 5 | Register file read index |
| rf_rdata | output | VLEN | Register file read data |

## Verification
The assertions watch, on every cycle, the single-outstanding rule and the pulse shape of req and done. They also check that a rejected operation issued no request, that a trap keeps the vector length captured at start, and that every normal retirement clears the start index without growing the vector length. The field order, the address arithmetic, the register placement, sign extension, mask and start-index skipping, tail zeroing, and the exact shrunken length after a late fault all depend on data. Only the bench scenarios show them, by comparing the whole register file and the done outputs with a model after each operation, including a sweep that injects the fault at each element position in turn.

// File: rtl/fof_seg_loader.sv
module fof_seg_loader #(
  parameter int VLEN = 64,
  parameter int AW = 32,
  localparam int IW = $clog2(VLEN + 1),
  localparam int LVL = $clog2(VLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      sew_sel,
  input  logic [1:0]      lmul_sel,
  input  logic [2:0]      nf,
  input  logic [1:0]      msz,
  input  logic            sgn,
  input  logic            vm,
  input  logic            vtype_bad,
  input  logic [4:0]      rd,
  input  logic [IW-1:0]   vl_in,
  input  logic [IW-1:0]   vstart_in,
  input  logic [AW-1:0]   base,
  input  logic [VLEN-1:0] mask,
  output logic            req,
  output logic [AW-1:0]   req_addr,
  output logic [1:0]      req_size,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_data,
  input  logic            rsp_fault,
  output logic            done,
  output logic            ill,
  output logic            trap,
  output logic [AW-1:0]   trap_addr,
  output logic [IW-1:0]   vl_out,
  output logic [IW-1:0]   vstart_out,
  input  logic [4:0]      rf_raddr,
  output logic [VLEN-1:0] rf_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ELEM, S_REQ, S_WAIT, S_TAIL, S_FIN} st_t;
  st_t st;

  logic [1:0]      sew_q, lmul_q, esz_q;
  logic [2:0]      nf_q, k_q;
  logic            sgn_q, vm_q;
  logic [4:0]      rd_q;
  logic [IW-1:0]   vl0_q, vs0_q, vmax_q, i_q, run_q;
  logic [AW-1:0]   base_q;
  logic [VLEN-1:0] mask_q;
  logic [VLEN-1:0] rf [32];

  logic            bad_cfg;
  logic [IW-1:0]   vmax_calc;
  logic [AW-1:0]   item_idx;
  logic [4:0]      wr_reg;
  logic [31:0]     pos;
  logic [63:0]     fmask, xd;
  logic [VLEN-1:0] wmask, wdata;
  logic            wr_en;

  assign bad_cfg = vtype_bad | (!vm && rd == 5'd0)
                 | ((({4'b0, nf} + 7'd1) << lmul_sel) > 7'd32)
                 | (msz != 2'd3 && msz > sew_sel);
  assign vmax_calc = IW'((VLEN << lmul_sel) >> (3 + sew_sel));

  assign item_idx = AW'(i_q) * AW'({1'b0, nf_q} + 4'd1) + AW'(k_q);
  assign req_addr = base_q + (item_idx << esz_q);
  assign req_size = esz_q;
  assign req      = (st == S_REQ);
  assign done     = (st == S_FIN);
  assign rf_rdata = rf[rf_raddr];

  always_comb begin
    int unsigned epr_l;
    epr_l  = LVL - 3 - 32'(sew_q);
    wr_reg = 5'(32'(rd_q) + (32'(i_q) >> epr_l) + (32'(k_q) << lmul_q));
    pos    = (32'(i_q) & ((32'd1 << epr_l) - 32'd1)) << (3 + 32'(sew_q));
    fmask  = (sew_q == 2'd3) ? '1 : ((64'd1 << (32'd8 << sew_q)) - 64'd1);
    case (esz_q)
      2'd0:    xd = {{56{sgn_q & rsp_data[7]}},  rsp_data[7:0]};
      2'd1:    xd = {{48{sgn_q & rsp_data[15]}}, rsp_data[15:0]};
      2'd2:    xd = {{32{sgn_q & rsp_data[31]}}, rsp_data[31:0]};
      default: xd = rsp_data;
    endcase
    wmask = VLEN'(fmask) << pos;
    wdata = (st == S_TAIL) ? '0 : (VLEN'(xd) << pos);
    wr_en = (st == S_TAIL) | (st == S_WAIT && rsp_valid && !rsp_fault);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 32; r++) rf[r] <= {(VLEN/8){8'h80 | 8'(r)}};
    end else if (wr_en) begin
      rf[wr_reg] <= (rf[wr_reg] & ~wmask) | (wdata & wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sew_q <= '0; lmul_q <= '0; esz_q <= '0; nf_q <= '0; k_q <= '0;
      sgn_q <= 1'b0; vm_q <= 1'b1; rd_q <= '0;
      vl0_q <= '0; vs0_q <= '0; vmax_q <= '0; i_q <= '0; run_q <= '0;
      base_q <= '0; mask_q <= '0;
      ill <= 1'b0; trap <= 1'b0; trap_addr <= '0; vl_out <= '0; vstart_out <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sew_q  <= sew_sel;
          lmul_q <= lmul_sel;
          esz_q  <= (msz == 2'd3) ? sew_sel : msz;
          nf_q   <= nf;
          sgn_q  <= sgn && msz != 2'd3;
          vm_q   <= vm;
          rd_q   <= rd;
          vl0_q  <= vl_in;
          vs0_q  <= vstart_in;
          vmax_q <= vmax_calc;
          base_q <= base;
          mask_q <= mask;
          i_q    <= '0;
          run_q  <= '0;
          trap   <= 1'b0;
          trap_addr <= '0;
          ill    <= bad_cfg;
          if (bad_cfg) begin
            vl_out     <= vl_in;
            vstart_out <= vstart_in;
            st         <= S_FIN;
          end else begin
            st <= S_ELEM;
          end
        end
        S_ELEM: begin
          if (i_q == vmax_q) begin
            vl_out     <= vl0_q;
            vstart_out <= '0;
            st         <= S_FIN;
          end else if (i_q < vs0_q) begin
            i_q <= i_q + 1'b1;
          end else if (i_q < vl0_q) begin
            if (vm_q || mask_q[i_q[LVL-1:0]]) begin
              k_q <= nf_q;
              st  <= S_REQ;
            end else begin
              run_q <= run_q + 1'b1;
              i_q   <= i_q + 1'b1;
            end
          end else begin
            k_q <= nf_q;
            st  <= S_TAIL;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_fault) begin
            trap       <= (run_q == '0);
            trap_addr  <= req_addr;
            vl_out     <= (run_q == '0) ? vl0_q : run_q;
            vstart_out <= (run_q == '0) ? i_q : '0;
            st         <= S_FIN;
          end else if (k_q == 3'd0) begin
            i_q   <= i_q + 1'b1;
            run_q <= run_q + 1'b1;
            st    <= S_ELEM;
          end else begin
            k_q <= k_q - 1'b1;
            st  <= S_REQ;
          end
        end
        S_TAIL: begin
          if (k_q == 3'd0) begin
            i_q <= i_q + 1'b1;
            st  <= S_ELEM;
          end else begin
            k_q <= k_q - 1'b1;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module fof_seg_loader_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW-1:0] vl_in,
  input logic          req,
  input logic          rsp_valid,
  input logic          done,
  input logic          ill,
  input logic          trap,
  input logic [IW-1:0] vl_out,
  input logic [IW-1:0] vstart_out
);

  logic          busy, outst, req_seen;
  logic [IW-1:0] vl_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; outst <= 1'b0; req_seen <= 1'b0; vl_cap <= '0;
    end else begin
      if (done) busy <= 1'b0;
      else if (start && !busy) begin
        busy <= 1'b1;
        vl_cap <= vl_in;
        req_seen <= 1'b0;
      end
      if (req) begin
        outst <= 1'b1;
        req_seen <= 1'b1;
      end else if (rsp_valid) outst <= 1'b0;
    end
  end

  p_single_outst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !outst);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ill_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ill) |-> !req_seen);
  p_trap_keeps_vl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trap) |-> (vl_out == vl_cap));
  p_retire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap && !ill) |-> (vstart_out == '0 && vl_out <= vl_cap));

endmodule

bind fof_seg_loader fof_seg_loader_chk #(.IW(IW)) u_chk (.*);

// File: tb/tb_fof_seg_loader.sv
module tb_fof_seg_loader;
  localparam int VLEN = 64;
  localparam int AW = 32;
  localparam int IW = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] sew_sel = '0, lmul_sel = '0, msz = '0;
  logic [2:0] nf = '0;
  logic sgn = 1'b0, vm = 1'b1, vtype_bad = 1'b0;
  logic [4:0] rd = 5'd1;
  logic [IW-1:0] vl_in = '0, vstart_in = '0;
  logic [AW-1:0] base = '0;
  logic [VLEN-1:0] mask = '0;
  logic req; logic [AW-1:0] req_addr; logic [1:0] req_size;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [63:0] rsp_data = '0;
  logic done, ill, trap;
  logic [AW-1:0] trap_addr;
  logic [IW-1:0] vl_out, vstart_out;
  logic [4:0] rf_raddr = '0;
  logic [VLEN-1:0] rf_rdata;

  fof_seg_loader #(.VLEN(VLEN), .AW(AW)) dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, req_cnt = 0;
  logic fault_en = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  logic [63:0] exp_rf [32];
  logic ex_ill, ex_trap;
  logic [AW-1:0] ex_taddr;
  int ex_vl, ex_vs, ex_reqs;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req) begin
        logic [AW-1:0] a;
        a = req_addr;
        req_cnt++;
        repeat (1 + $urandom % 3) @(negedge clk);
        for (int n = 0; n < 8; n++) rsp_data[8*n +: 8] = mb(a + AW'(n));
        rsp_fault = fault_en && (a == fault_addr);
        rsp_valid = 1'b1;
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic put(input int r, input int j, input int s, input logic [63:0] v);
    logic [63:0] m;
    m = (s == 64) ? '1 : ((64'd1 << s) - 64'd1);
    exp_rf[r] = (exp_rf[r] & ~(m << (j * s))) | ((v & m) << (j * s));
  endtask

  task automatic ref_run();
    int L, S, B, vmax, epr, run;
    bit stop;
    L = 1 << lmul_sel; S = 8 << sew_sel;
    B = (msz == 3) ? S / 8 : (1 << msz);
    vmax = VLEN * L / S; epr = VLEN / S;
    ex_trap = 0; ex_taddr = '0; ex_reqs = 0;
    ex_ill = vtype_bad || (!vm && rd == 0) || ((nf + 1) * L > 32) || (msz != 3 && (1 << msz) > S / 8);
    if (ex_ill) begin ex_vl = vl_in; ex_vs = vstart_in; return; end
    run = 0; stop = 0;
    for (int i = 0; i < vmax && !stop; i++) begin
      if (i < vstart_in) continue;
      if (i < vl_in) begin
        if (vm || mask[i]) begin
          for (int k = nf; k >= 0 && !stop; k--) begin
            logic [AW-1:0] a;
            logic [63:0] v;
            a = base + AW'((i * (nf + 1) + k) * B);
            ex_reqs++;
            if (fault_en && a == fault_addr) begin
              stop = 1;
              if (run == 0) begin ex_trap = 1; ex_taddr = a; ex_vl = vl_in; ex_vs = i; end
              else begin ex_vl = run; ex_vs = 0; end
            end else begin
              v = '0;
              for (int n = 0; n < B; n++) v[8*n +: 8] = mb(a + AW'(n));
              if (sgn && msz != 3 && B < 8 && v[8*B-1]) v = v | ~((64'd1 << (8*B)) - 64'd1);
              put((rd + i / epr + k * L) % 32, i % epr, S, v);
            end
          end
          if (!stop) run++;
        end else run++;
      end else begin
        for (int k = nf; k >= 0; k--) put((rd + i / epr + k * L) % 32, i % epr, S, 64'd0);
      end
    end
    if (!stop) begin ex_vl = vl_in; ex_vs = 0; end
  endtask

  task automatic run_op(input string tag, input bit stray);
    int n, r0;
    bit regs_ok;
    r0 = req_cnt;
    ref_run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (stray) begin
      @(negedge clk); vtype_bad = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0; vtype_bad = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, {tag, " done seen"}, 64'(done), 64'd1);
    chk(ill == ex_ill, {tag, " R1 ill flag"}, 64'(ill), 64'(ex_ill));
    chk(trap == ex_trap, {tag, " R9 trap flag"}, 64'(trap), 64'(ex_trap));
    if (ex_trap) chk(trap_addr == ex_taddr, {tag, " R9 trap_addr"}, 64'(trap_addr), 64'(ex_taddr));
    chk(int'(vl_out) == ex_vl, {tag, " R7/R8 vl_out"}, 64'(vl_out), 64'(ex_vl));
    chk(int'(vstart_out) == ex_vs, {tag, " R7/R9 vstart_out"}, 64'(vstart_out), 64'(ex_vs));
    chk(req_cnt - r0 == ex_reqs, {tag, " R10 request count"}, 64'(req_cnt - r0), 64'(ex_reqs));
    @(negedge clk);
    chk(!done, {tag, " R12 done pulse"}, 64'(done), 64'd0);
    regs_ok = 1;
    for (int r = 0; r < 32; r++) begin
      rf_raddr = 5'(r); #1;
      if (rf_rdata !== exp_rf[r] && regs_ok) begin
        regs_ok = 0;
        chk(0, $sformatf("%s regs v%0d", tag, r), rf_rdata, exp_rf[r]);
      end
    end
    if (regs_ok) chk(1, {tag, " regs"}, 0, 0);
  endtask

  task automatic cfg(input int s, input int l, input int f, input int m, input bit sg,
                     input bit vmm, input int d, input int v, input int vs);
    sew_sel = 2'(s); lmul_sel = 2'(l); nf = 3'(f); msz = 2'(m); sgn = sg;
    vm = vmm; rd = 5'(d); vl_in = IW'(v); vstart_in = IW'(vs);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < 32; r++) exp_rf[r] = {8{8'h80 | 8'(r)}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!done && !req, "R11 done/req low after reset", 64'({done, req}), 64'd0);
    rf_raddr = 5'd0; #1; chk(rf_rdata == exp_rf[0], "R11 reset v0", rf_rdata, exp_rf[0]);
    rf_raddr = 5'd31; #1; chk(rf_rdata == exp_rf[31], "R11 reset v31", rf_rdata, exp_rf[31]);

    // R1 rejected operations
    base = 32'h1000; mask = {$urandom, $urandom};
    cfg(0, 3, 4, 0, 0, 1, 8, 10, 0); run_op("R1 lmul*fields", 0);
    cfg(1, 0, 0, 2, 0, 1, 4, 3, 1); run_op("R1 item wider than SEW", 0);
    cfg(2, 0, 1, 3, 0, 0, 0, 2, 0); run_op("R1 masked rd0", 0);
    cfg(0, 0, 0, 0, 0, 1, 3, 4, 0); vtype_bad = 1'b1; run_op("R1 bad vtype", 0); vtype_bad = 1'b0;

    // R2/R3/R4 plain loads, R12 stray start ignored while busy
    base = 32'h0000_2000;
    cfg(0, 0, 1, 0, 1, 1, 2, 8, 0); run_op("R2/R3/R4/R12 bytes signed", 1);
    cfg(2, 1, 2, 0, 1, 1, 5, 4, 0); run_op("R4 byte sign-extend to 32", 0);
    cfg(3, 0, 0, 1, 0, 1, 9, 1, 0); run_op("R4 half zero-extend to 64", 0);
    // R5 vstart skip and masked-off elements, R6 tail zero
    mask = 64'hA5;
    cfg(1, 1, 1, 3, 0, 0, 6, 6, 2); run_op("R5/R6 mask and vstart", 0);

    // fault at each element position in turn (R8 / R9)
    mask = '1;
    for (int e = 0; e < 8; e++) begin
      cfg(1, 1, 1, 3, 0, 1, 10, 6, 0);
      base = 32'h0000_3000;
      fault_en = 1'b1; fault_addr = base + AW'((e * 2 + 0) * 2);
      run_op($sformatf("R8/R9 fault elem %0d", e), 0);
    end
    cfg(0, 0, 2, 0, 0, 1, 12, 8, 3);
    fault_addr = base + AW'((3 * 3 + 2) * 1);
    run_op("R9 trap at vstart element", 0);
    fault_en = 1'b0;

    // constrained random operations
    for (int t = 0; t < 40; t++) begin
      int s, l, f, m, vmax, v, vs;
      bit vmm;
      do begin
        s = $urandom % 4; l = $urandom % 4; f = $urandom % 8;
      end while ((f + 1) << l > 32);
      m = ($urandom % 2) ? 3 : ($urandom % (s + 1));
      if (m > 2) m = 3;
      vmax = VLEN * (1 << l) / (8 << s);
      v = $urandom % (vmax + 1);
      vs = ($urandom % 4 == 0) ? ($urandom % (v + 2)) : 0;
      vmm = $urandom % 2;
      cfg(s, l, f, m, $urandom % 2, vmm, vmm ? $urandom % 32 : 1 + $urandom % 31, v, vs);
      base = $urandom & 32'h00FF_FFF8;
      mask = {$urandom, $urandom};
      fault_en = $urandom % 2;
      if (fault_en && vmax > 0) begin
        int B;
        B = (m == 3) ? (1 << s) : (1 << m);
        fault_addr = base + AW'((($urandom % vmax) * (f + 1) + ($urandom % (f + 1))) * B);
      end
      run_op($sformatf("R2/R3/R5/R6 random %0d", t), 0);
    end
    fault_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule